// File: doc/BRIEF.md
# Serial RGB LED Chain Driver

The block drives one chain of single-wire serial RGB LEDs and refreshes the whole chain without pause. It walks an LED address port through the chain and reads each LED's 24-bit colour from an external synchronous pixel store. The store returns red, green and blue bytes one clock after it sees an address. Each colour is shifted out as timed high/low pulses on one data line. After the last LED the line stays low for the latch gap, and then the next refresh starts from address 0.

All pulse widths are set in picoseconds and converted to clock counts against the clock period parameter. With the defaults (12.5 ns clock) a zero bit is 28 clocks high and 64 low, a one bit is 56 high and 48 low, and the latch gap is 6400 clocks. The next LED's address is issued while the current LED is still being sent, so consecutive LEDs follow with no idle time between them.

Top module: `led_chain_driver`

## Requirements
- R1: While rst_ni is low, dout_o is 0 and led_addr_o is 0, and both take these values as soon as reset is asserted, including in the middle of a refresh.
- R2: A zero bit is sent as exactly 28 clocks of dout_o high followed by exactly 64 clocks low.
- R3: A one bit is sent as exactly 56 clocks of dout_o high followed by exactly 48 clocks low.
- R4: Each LED's 24 bits are sent as the green byte, then the red byte, then the blue byte, each byte most significant bit first.
- R5: led_addr_o only ever moves from a to (a+1) mod NUM_LEDS and never holds a value of NUM_LEDS or more. When the first bit of LED k starts, led_addr_o already shows min(k+1, NUM_LEDS-1).
- R6: The colour sent for LED k is the one the store returns for address k with one clock of read latency. The first high phase after reset release (and after each latch gap) starts on the second rising edge after address 0 is presented.
- R7: After the last bit of the last LED, dout_o stays low for that bit's low phase plus 6400 plus 2 clocks. The rise that follows is the first bit of LED 0.
- R8: Every refresh sends exactly NUM_LEDS LEDs, refreshes repeat with no end, and each refresh sends the store contents current at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; period given by CLK_PERIOD_PS |
| rst_ni | input | 1 | Asynchronous active-low reset |
| red_i | input | COLOR_W | Red byte from the pixel store, one clock after the address |
| green_i | input | COLOR_W | Green byte from the pixel store |
| blue_i | input | COLOR_W | Blue byte from the pixel store |
| led_addr_o | output | ADDR_W | LED address presented to the pixel store |
| dout_o | output | 1 | Serial data line to the LED chain |

## Verification
The line rises two rising edges after address 0 appears, on the edge that captures the store output. The bench therefore expects the first high sample on the third falling edge after a reset release made just after a rising edge. Every pulse is measured as a run of falling-edge samples, and each high/low pair is checked when the next rise ends it. This puts the pixel and latch-gap checks of the last LED at the first rise of the following refresh. The address is checked on the falling edge after every change, and again on the falling edge after each LED's first rise, one clock after the load edge. The bench store changes its contents only in the middle of a latch gap, which lets each refresh be compared against one known pattern.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

  typedef enum logic [1:0] {
    SEQ_ADDR,
    SEQ_FETCH,
    SEQ_SEND,
    SEQ_GAP
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_HIGH,
    PH_LOW
  } bit_phase_e;

  // nearest whole number of clocks for a duration
  function automatic int ps_to_cyc(int dur_ps, int clk_ps);
    return (dur_ps + clk_ps / 2) / clk_ps;
  endfunction

endpackage

// File: rtl/led_bit_timer.sv
module led_bit_timer import led_drv_pkg::*; #(
  parameter int T0H_CYC = 28,
  parameter int T0L_CYC = 64,
  parameter int T1H_CYC = 56,
  parameter int T1L_CYC = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic bit_i,
  output logic dout_o,
  output logic done_o
);

  localparam int HMAX   = (T0H_CYC > T1H_CYC) ? T0H_CYC : T1H_CYC;
  localparam int LMAX   = (T0L_CYC > T1L_CYC) ? T0L_CYC : T1L_CYC;
  localparam int PH_MAX = (HMAX > LMAX) ? HMAX : LMAX;
  localparam int CNT_W  = $clog2(PH_MAX + 1);

  bit_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             val_q;

  assign done_o = (phase_q == PH_LOW) && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      val_q   <= 1'b0;
      dout_o  <= 1'b0;
    end else if (start_i) begin
      phase_q <= PH_HIGH;
      val_q   <= bit_i;
      cnt_q   <= bit_i ? CNT_W'(T1H_CYC - 1) : CNT_W'(T0H_CYC - 1);
      dout_o  <= 1'b1;
    end else begin
      case (phase_q)
        PH_HIGH: begin
          if (cnt_q == '0) begin
            phase_q <= PH_LOW;
            cnt_q   <= val_q ? CNT_W'(T1L_CYC - 1) : CNT_W'(T0L_CYC - 1);
            dout_o  <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        PH_LOW: begin
          if (cnt_q == '0) phase_q <= PH_IDLE;
          else             cnt_q   <= cnt_q - 1'b1;
        end
        default: dout_o <= 1'b0;
      endcase
    end
  end

  // a new bit may only begin once the previous one has fully ended
  p_start_free_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (phase_q == PH_IDLE || done_o));

  // the line never rises outside a started bit
  p_rise_on_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && phase_q != PH_HIGH) |=> !dout_o);

endmodule

// File: rtl/led_pixel_shreg.sv
module led_pixel_shreg #(
  parameter int PIX_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             shift_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             next_bit_o,
  output logic             last_bit_o
);

  localparam int IDX_W = $clog2(PIX_W);

  logic [PIX_W-1:0] sr_q;
  logic [IDX_W-1:0] idx_q;

  assign next_bit_o = sr_q[PIX_W-2];
  assign last_bit_o = (idx_q == IDX_W'(PIX_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sr_q  <= pix_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sr_q  <= {sr_q[PIX_W-2:0], 1'b0};
      idx_q <= idx_q + 1'b1;
    end
  end

  p_no_overshift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !last_bit_o);

  p_load_shift_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && shift_i));

endmodule

// File: rtl/led_refresh_seq.sv
module led_refresh_seq import led_drv_pkg::*; #(
  parameter int NUM_LEDS = 256,
  parameter int ADDR_W   = 8,
  parameter int GAP_CYC  = 6400
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_done_i,
  input  logic              last_bit_i,
  output logic              load_o,
  output logic              shift_o,
  output logic              gap_o,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int               GAP_W    = $clog2(GAP_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST_LED = ADDR_W'(NUM_LEDS - 1);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] cur_q;
  logic [GAP_W-1:0]  gap_q;
  logic              last_led;
  logic              pix_end;

  assign last_led = (cur_q == LAST_LED);
  assign pix_end  = (state_q == SEQ_SEND) && bit_done_i && last_bit_i;
  assign load_o   = (state_q == SEQ_FETCH) || (pix_end && !last_led);
  assign shift_o  = (state_q == SEQ_SEND) && bit_done_i && !last_bit_i;
  assign gap_o    = (state_q == SEQ_GAP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_ADDR;
      addr_o  <= '0;
      cur_q   <= '0;
      gap_q   <= '0;
    end else begin
      // address of the next LED goes out while the current one is loaded
      if (load_o) begin
        cur_q <= addr_o;
        if (addr_o != LAST_LED) addr_o <= addr_o + 1'b1;
      end
      case (state_q)
        SEQ_ADDR:  state_q <= SEQ_FETCH;   // store sees the address
        SEQ_FETCH: state_q <= SEQ_SEND;    // store data captured
        SEQ_SEND: begin
          if (pix_end && last_led) begin
            state_q <= SEQ_GAP;
            gap_q   <= GAP_W'(GAP_CYC - 1);
          end
        end
        default: begin
          if (gap_q == '0) begin
            state_q <= SEQ_ADDR;
            addr_o  <= '0;
          end else begin
            gap_q <= gap_q - 1'b1;
          end
        end
      endcase
    end
  end

  p_addr_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_o <= LAST_LED);

  p_fetch_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_FETCH) |-> $stable(addr_o));

  p_gap_wraps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gap_o && gap_q == '0) |=> (addr_o == '0 && state_q == SEQ_ADDR));

  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(addr_o) |-> (addr_o == '0 || addr_o == $past(addr_o) + 1'b1));

endmodule

// File: rtl/led_chain_driver.sv
module led_chain_driver import led_drv_pkg::*; #(
  parameter int NUM_LEDS      = 256,
  parameter int ADDR_W        = 8,
  parameter int COLOR_W       = 8,
  parameter int CLK_PERIOD_PS = 12500,
  parameter int T0H_PS        = 350000,
  parameter int T0L_PS        = 800000,
  parameter int T1H_PS        = 700000,
  parameter int T1L_PS        = 600000,
  parameter int LATCH_PS      = 80000000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [COLOR_W-1:0] red_i,
  input  logic [COLOR_W-1:0] green_i,
  input  logic [COLOR_W-1:0] blue_i,
  output logic [ADDR_W-1:0]  led_addr_o,
  output logic               dout_o
);

  localparam int PIX_W   = 3 * COLOR_W;
  localparam int T0H_CYC = ps_to_cyc(T0H_PS, CLK_PERIOD_PS);
  localparam int T0L_CYC = ps_to_cyc(T0L_PS, CLK_PERIOD_PS);
  localparam int T1H_CYC = ps_to_cyc(T1H_PS, CLK_PERIOD_PS);
  localparam int T1L_CYC = ps_to_cyc(T1L_PS, CLK_PERIOD_PS);
  localparam int GAP_CYC = ps_to_cyc(LATCH_PS, CLK_PERIOD_PS);

  logic             load_w, shift_w, gap_w;
  logic             bit_done_w, last_bit_w, next_bit_w;
  logic             start_w, start_bit_w;
  logic [PIX_W-1:0] pix_w;

  // line order is green, red, blue
  assign pix_w       = {green_i, red_i, blue_i};
  assign start_w     = load_w | shift_w;
  assign start_bit_w = load_w ? green_i[COLOR_W-1] : next_bit_w;

  led_refresh_seq #(
    .NUM_LEDS (NUM_LEDS),
    .ADDR_W   (ADDR_W),
    .GAP_CYC  (GAP_CYC)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_done_i (bit_done_w),
    .last_bit_i (last_bit_w),
    .load_o     (load_w),
    .shift_o    (shift_w),
    .gap_o      (gap_w),
    .addr_o     (led_addr_o)
  );

  led_pixel_shreg #(
    .PIX_W (PIX_W)
  ) u_shreg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_w),
    .shift_i    (shift_w),
    .pix_i      (pix_w),
    .next_bit_o (next_bit_w),
    .last_bit_o (last_bit_w)
  );

  led_bit_timer #(
    .T0H_CYC (T0H_CYC),
    .T0L_CYC (T0L_CYC),
    .T1H_CYC (T1H_CYC),
    .T1L_CYC (T1L_CYC)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_w),
    .bit_i   (start_bit_w),
    .dout_o  (dout_o),
    .done_o  (bit_done_w)
  );

  p_gap_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_w |-> !dout_o);

  p_load_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_w |=> dout_o);

  p_gap_no_load_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_w |-> !(load_w || shift_w));

endmodule

// File: tb/sim_led_chain_driver.sv
module sim_led_chain_driver;

  localparam int N  = 3;
  localparam int G  = 6400;
  localparam int H0 = 28;
  localparam int L0 = 64;
  localparam int H1 = 56;
  localparam int L1 = 48;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] r_s = '0, g_s = '0, b_s = '0;
  logic [7:0] addr;
  logic       dout;

  int page = 0;
  int exp_page = 0;
  int checks = 0;
  int fails = 0;
  int frames = 0;
  bit done_run = 0;

  always #4 clk = ~clk;

  function automatic logic [23:0] pat(int pg, int idx);
    logic [7:0] pr, pgr, pb;
    if (pg == 1) return 24'h000000;
    if (pg == 2) return 24'hFFFFFF;
    pr  = 8'(pg * 37 + idx * 91 + 5);
    pgr = 8'((pg * 53) ^ (idx * 29) ^ 165);
    pb  = 8'(255 - ((pg * 17 + idx * 7) % 256));
    return {pr, pgr, pb};
  endfunction

  // pixel store with one clock of read latency
  always @(posedge clk) {r_s, g_s, b_s} <= pat(page, int'(addr));

  led_chain_driver #(.NUM_LEDS(N)) u0 (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .red_i      (r_s),
    .green_i    (g_s),
    .blue_i     (b_s),
    .led_addr_o (addr),
    .dout_o     (dout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  bit          mon_en = 0;
  logic        prev;
  int          hi, lo, bitn, pixn, since_rel;
  bit          seen_hi;
  logic [23:0] word;
  logic [7:0]  last_addr;

  task automatic end_bit();
    bit          bv;
    int          exp_lo;
    logic [23:0] p;
    logic [23:0] exp_w;
    bit          gap;
    bv = (hi == H1);
    if (bv) chk(hi == H1, "R3 high", hi, H1);
    else    chk(hi == H0, "R2 high", hi, H0);
    gap = (lo > L0);
    if (gap) begin
      exp_lo = (bv ? L1 : L0) + G + 2;
      chk(lo == exp_lo, "R7 gap", lo, exp_lo);
    end else if (bv) chk(lo == L1, "R3 low", lo, L1);
    else             chk(lo == L0, "R2 low", lo, L0);
    word = {word[22:0], bv};
    bitn++;
    if (bitn == 24) begin
      p     = pat(exp_page, pixn);
      exp_w = {p[15:8], p[23:16], p[7:0]};
      chk(word == exp_w, "R4 pixel", int'(word), int'(exp_w));
      bitn = 0;
      pixn++;
    end
    if (gap) begin
      chk(pixn == N && bitn == 0, "R8 count", pixn, N);
      pixn = 0;
      bitn = 0;
      exp_page++;
      frames++;
    end
  endtask

  always @(negedge clk) begin
    if (!mon_en) begin
      prev = 1'b0; hi = 0; lo = 0; bitn = 0; pixn = 0; word = '0;
      since_rel = 0; seen_hi = 0; last_addr = addr;
    end else begin
      since_rel++;
      if (addr !== last_addr) begin
        chk(addr < N && int'(addr) == (int'(last_addr) + 1) % N, "R5 step",
            int'(addr), (int'(last_addr) + 1) % N);
        last_addr = addr;
      end
      if (dout && !prev) begin
        if (!seen_hi) chk(since_rel == 3, "R6 first rise", since_rel, 3);
        else end_bit();
        seen_hi = 1;
        hi = 1;
        lo = 0;
        if (bitn == 0)
          chk(int'(addr) == ((pixn + 1 < N) ? pixn + 1 : N - 1), "R5 prefetch",
              int'(addr), (pixn + 1 < N) ? pixn + 1 : N - 1);
      end else if (dout) begin
        hi++;
      end else begin
        lo++;
        if (lo == 200) page++;  // only reachable inside the latch gap
      end
      prev = dout;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(dout == 1'b0, "R1 reset dout", int'(dout), 0);
    chk(addr == 8'd0, "R1 reset addr", int'(addr), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    mon_en = 1;
    wait (frames >= 4);
    wait (pixn == 1 && bitn == 5);
    @(posedge clk); #2;
    rst_n = 1'b0;
    mon_en = 0;
    @(negedge clk);
    chk(dout == 1'b0, "R1 mid reset dout", int'(dout), 0);
    chk(addr == 8'd0, "R1 mid reset addr", int'(addr), 0);
    repeat (3) @(negedge clk);
    @(posedge clk); #2;
    rst_n = 1'b1;
    mon_en = 1;
    wait (frames >= 6);
    chk(frames == 6, "R8 refreshes", frames, 6);
    finish_run();
  end

  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "watchdog", frames, 6);
    finish_run();
  end

endmodule